// File: doc/BRIEF.md
# Console Port Address Register Unit

This unit keeps the address state that a console or debug port uses when it reads and writes memory over a processor bus. Software loads the state through three register writes: a low-address write, a high-address write and a byte-enable write. Each memory command then gets, one clock later, a registered bus request with a 22-bit byte address held as a 21-bit word address, a remote-access flag, two byte enables, a 22-bit-mode enable and a map enable.

Commands marked auto-increment step the stored word address, so block transfers need only one address load. A window form of the command reaches a fixed 4 KiW page at the top of the 16-bit space. It ignores the stored address, sets the remote-access flag and is the only form that shows the programmed byte enables. The bus transaction, the processor and the decoding of the command stream sit outside this unit.

Top module: `conaddr_unit`

## Requirements
- R1: After reset the stored word address is 0, both mode enables are 0, the stored byte enables are 11, the sticky flag is 0, and `bus_valid` is 0.
- R2: A low-address write (`lo_wr`) loads address bits 15:1 from `wr_data[15:1]` and clears address bits 21:16, the 22-bit enable and the map enable. When `lo_wr` and `hi_wr` occur in the same cycle, the low write wins.
- R3: A high-address write (`hi_wr`) loads address bits 21:16 from `wr_data[5:0]`, the 22-bit enable from `wr_data[6]` and the map enable from `wr_data[7]`. Address bits 15:1 stay unchanged.
- R4: For a command in cycle N (`cmd_valid`=1), the outputs in cycle N+1 show `bus_valid`=1 for exactly one cycle and `bus_write`=`cmd_write`. For a non-window command they also show `bus_addr` as the stored address before the command, the stored mode enables, `bus_racc`=0 and `bus_be`=11.
- R5: A non-window command with `cmd_incr`=1 adds one to the stored word address, wrapping from all ones to 0, and leaves the mode enables unchanged. Without `cmd_incr`, the stored address is kept.
- R6: A byte-enable write (`be_wr`) loads the stored enables from `wr_data[1:0]` and the sticky flag from `wr_data[2]`.
- R7: A window command outputs address bits 21:16 as 0, bits 15:13 as 111 and bits 12:1 from `cmd_offset[12:1]`. It also outputs `bus_racc`=1, `bus_be` equal to the stored enables, and both mode enables as 0. It never changes the stored address, even with `cmd_incr`=1.
- R8: After any write command, window or not, with the sticky flag 0, the stored byte enables become 11. Read commands, and write commands with the sticky flag 1, leave them unchanged.
- R9: When any register write coincides with a command, the command's output uses the state from before the write. The register write takes effect, and that command's increment and byte-enable fallback are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_wr | input | 1 | Low-address register write strobe |
| hi_wr | input | 1 | High-address register write strobe |
| be_wr | input | 1 | Byte-enable register write strobe |
| wr_data | input | DATA_W | Register write data |
| cmd_valid | input | 1 | Memory command strobe |
| cmd_write | input | 1 | 1 = memory write, 0 = memory read |
| cmd_incr | input | 1 | Auto-increment qualifier |
| cmd_window | input | 1 | Window access qualifier |
| cmd_offset | input | WIN_W-1 | Window word offset (byte offset bits 12:1) |
| bus_valid | output | 1 | Registered request strobe, one cycle per command |
| bus_write | output | 1 | Request direction |
| bus_addr | output | ADDR_W-1 | Word address, byte address bits 21:1 |
| bus_racc | output | 1 | Remote-access flag, set on window commands |
| bus_be | output | DATA_W/8 | Byte enables |
| bus_en22 | output | 1 | 22-bit addressing enable |
| bus_enmap | output | 1 | Address map enable |

## Verification
The bench drives increments through the wrap from all ones to zero with the 22-bit enable set. A design that carried into a flag, or that saturated, would show a wrong address or a cleared mode on the next read. It runs byte-enable sequences that tell window writes, plain writes and reads apart under both sticky settings. A design that reverted only on window writes, reverted on reads, or leaked the programmed enables into plain accesses would show the wrong `bus_be` on the following window read. It also collides register writes with incrementing and writing commands, and writes both address halves in one cycle. A design that used the new state for the colliding command, applied both updates, or let the high write win would show an offset address on the next read.

// File: rtl/conaddr_pkg.sv
package conaddr_pkg;

  typedef struct packed {
    logic en22;
    logic enmap;
  } mode_t;

  localparam mode_t MODE_OFF = '{en22: 1'b0, enmap: 1'b0};

endpackage

// File: rtl/conaddr_loc.sv
module conaddr_loc
  import conaddr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inc_en,
  output logic [ADDR_W-1:1] st_addr,
  output mode_t             st_mode
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int WA_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:1] ONE_WORD = {{(WA_W-1){1'b0}}, 1'b1};

  // word step, wraps modulo 2^(ADDR_W-1)
  function automatic logic [ADDR_W-1:1] next_word(input logic [ADDR_W-1:1] a);
    return a + ONE_WORD;
  endfunction

  // low write image: high part cleared
  function automatic logic [ADDR_W-1:1] lo_image(input logic [DATA_W-1:0] d);
    return {{HI_W{1'b0}}, d[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_addr <= '0;
      st_mode <= MODE_OFF;
    end else if (lo_wr) begin
      st_addr <= lo_image(wr_data);
      st_mode <= MODE_OFF;
    end else if (hi_wr) begin
      st_addr[ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
      st_mode.en22  <= wr_data[HI_W];
      st_mode.enmap <= wr_data[HI_W+1];
    end else if (inc_en) begin
      st_addr <= next_word(st_addr);
    end
  end

endmodule

// File: rtl/conaddr_bemask.sv
module conaddr_bemask #(
  parameter int BE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            be_wr,
  input  logic [BE_W-1:0] be_in,
  input  logic            sticky_in,
  input  logic            revert,
  output logic [BE_W-1:0] st_be,
  output logic            st_sticky
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_be     <= '1;
      st_sticky <= 1'b0;
    end else if (be_wr) begin
      st_be     <= be_in;
      st_sticky <= sticky_in;
    end else if (revert) begin
      st_be     <= '1;
    end
  end

endmodule

// File: rtl/conaddr_issue.sv
module conaddr_issue
  import conaddr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 13,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_window,
  input  logic [WIN_W-1:1]  cmd_offset,
  input  logic [ADDR_W-1:1] st_addr,
  input  mode_t             st_mode,
  input  logic [BE_W-1:0]   st_be,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:1] bus_addr,
  output logic              bus_racc,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_en22,
  output logic              bus_enmap
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int PAGE_W = DATA_W - WIN_W;

  // fixed page at the top of the 16-bit space
  function automatic logic [ADDR_W-1:1] window_addr(input logic [WIN_W-1:1] off);
    return {{HI_W{1'b0}}, {PAGE_W{1'b1}}, off};
  endfunction

  logic [ADDR_W-1:1] nx_addr;
  logic [BE_W-1:0]   nx_be;
  mode_t             nx_mode;

  always_comb begin
    if (cmd_window) begin
      nx_addr = window_addr(cmd_offset);
      nx_be   = st_be;
      nx_mode = MODE_OFF;
    end else begin
      nx_addr = st_addr;
      nx_be   = '1;
      nx_mode = st_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_racc  <= 1'b0;
      bus_be    <= '1;
      bus_en22  <= 1'b0;
      bus_enmap <= 1'b0;
    end else begin
      bus_valid <= cmd_valid;
      if (cmd_valid) begin
        bus_write <= cmd_write;
        bus_addr  <= nx_addr;
        bus_racc  <= cmd_window;
        bus_be    <= nx_be;
        bus_en22  <= nx_mode.en22;
        bus_enmap <= nx_mode.enmap;
      end
    end
  end

endmodule

// File: rtl/conaddr_unit.sv
module conaddr_unit
  import conaddr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 13,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              be_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_incr,
  input  logic              cmd_window,
  input  logic [WIN_W-1:1]  cmd_offset,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:1] bus_addr,
  output logic              bus_racc,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_en22,
  output logic              bus_enmap
);

  logic [ADDR_W-1:1] st_addr;
  mode_t             st_mode;
  logic [BE_W-1:0]   st_be;
  logic              st_sticky;

  // named events for the checker
  logic any_reg_wr;
  logic ev_incr;
  logic ev_revert;

  assign any_reg_wr = lo_wr | hi_wr | be_wr;
  assign ev_incr    = cmd_valid & cmd_incr & ~cmd_window & ~any_reg_wr;
  assign ev_revert  = cmd_valid & cmd_write & ~st_sticky & ~any_reg_wr;

  conaddr_loc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .wr_data (wr_data),
    .inc_en  (ev_incr),
    .st_addr (st_addr),
    .st_mode (st_mode)
  );

  conaddr_bemask #(.BE_W(BE_W)) u_be (
    .clk       (clk),
    .rst_n     (rst_n),
    .be_wr     (be_wr),
    .be_in     (wr_data[BE_W-1:0]),
    .sticky_in (wr_data[BE_W]),
    .revert    (ev_revert),
    .st_be     (st_be),
    .st_sticky (st_sticky)
  );

  conaddr_issue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .BE_W(BE_W)
  ) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_window (cmd_window),
    .cmd_offset (cmd_offset),
    .st_addr    (st_addr),
    .st_mode    (st_mode),
    .st_be      (st_be),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_racc   (bus_racc),
    .bus_be     (bus_be),
    .bus_en22   (bus_en22),
    .bus_enmap  (bus_enmap)
  );

endmodule

// File: rtl/conaddr_unit_chk.sv
module conaddr_unit_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 13,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lo_wr,
  input logic              hi_wr,
  input logic              be_wr,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic              cmd_window,
  input logic              bus_valid,
  input logic [ADDR_W-1:1] bus_addr,
  input logic              bus_racc,
  input logic [BE_W-1:0]   bus_be,
  input logic              bus_en22,
  input logic              bus_enmap,
  input logic [ADDR_W-1:1] st_addr,
  input logic              st_en22,
  input logic              st_enmap,
  input logic [BE_W-1:0]   st_be,
  input logic              st_sticky,
  input logic              ev_incr,
  input logic              ev_revert
);

  localparam int WA_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:1] ONE_WORD = {{(WA_W-1){1'b0}}, 1'b1};

  a_r4_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> bus_valid);

  a_r4_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !bus_valid);

  a_r4_plain_full_be: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_racc) |-> (bus_be == '1));

  a_r7_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_racc) |-> (!bus_en22 && !bus_enmap &&
      bus_addr[DATA_W-1:WIN_W] == '1 && bus_addr[ADDR_W-1:DATA_W] == '0));

  a_r7_racc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (bus_racc == $past(cmd_window)));

  a_r7_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_window && !lo_wr && !hi_wr) |=> $stable(st_addr));

  a_r2_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (st_addr[ADDR_W-1:DATA_W] == '0 && !st_en22 && !st_enmap));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incr |=> (st_addr == $past(st_addr) + ONE_WORD));

  a_r5_modes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incr |=> ($stable(st_en22) && $stable(st_enmap)));

  a_r8_revert: assert property (@(posedge clk) disable iff (!rst_n)
    ev_revert |=> (st_be == '1));

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && st_sticky && !be_wr) |=> $stable(st_be));

  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && !be_wr) |=> $stable(st_be));

endmodule

bind conaddr_unit conaddr_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .BE_W(BE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lo_wr      (lo_wr),
  .hi_wr      (hi_wr),
  .be_wr      (be_wr),
  .cmd_valid  (cmd_valid),
  .cmd_write  (cmd_write),
  .cmd_window (cmd_window),
  .bus_valid  (bus_valid),
  .bus_addr   (bus_addr),
  .bus_racc   (bus_racc),
  .bus_be     (bus_be),
  .bus_en22   (bus_en22),
  .bus_enmap  (bus_enmap),
  .st_addr    (st_addr),
  .st_en22    (st_mode.en22),
  .st_enmap   (st_mode.enmap),
  .st_be      (st_be),
  .st_sticky  (st_sticky),
  .ev_incr    (ev_incr),
  .ev_revert  (ev_revert)
);

// File: tb/conaddr_unit_test.sv
module conaddr_unit_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        lo_wr, hi_wr, be_wr;
  logic [15:0] wr_data;
  logic        cmd_valid, cmd_write, cmd_incr, cmd_window;
  logic [12:1] cmd_offset;
  logic        bus_valid, bus_write, bus_racc, bus_en22, bus_enmap;
  logic [21:1] bus_addr;
  logic [1:0]  bus_be;

  conaddr_unit uut (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .be_wr(be_wr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_incr(cmd_incr), .cmd_window(cmd_window), .cmd_offset(cmd_offset),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_racc(bus_racc), .bus_be(bus_be), .bus_en22(bus_en22),
    .bus_enmap(bus_enmap)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected item: {write, addr[21:1], racc, be, en22, enmap}
  logic [26:0] exp_q[$];
  string       tag_q[$];

  // bench model of the stored state
  logic [20:0] m_addr;
  logic        m_en22, m_enmap, m_sticky;
  logic [1:0]  m_be;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle of stimulus; pushes the expected request, updates the model
  task automatic step(input logic lo, input logic hi, input logic be,
                      input logic [15:0] d, input logic cv, input logic cw,
                      input logic ci, input logic cwin, input logic [12:1] off,
                      input string tag);
    logic [21:0] sum;
    lo_wr = lo; hi_wr = hi; be_wr = be; wr_data = d;
    cmd_valid = cv; cmd_write = cw; cmd_incr = ci; cmd_window = cwin;
    cmd_offset = off;
    if (cv) begin
      if (cwin) exp_q.push_back({cw, 6'd0, 3'b111, off, 1'b1, m_be, 2'b00});
      else      exp_q.push_back({cw, m_addr, 1'b0, 2'b11, m_en22, m_enmap});
      tag_q.push_back(tag);
    end
    if (lo) begin
      m_addr = {6'd0, d[15:1]}; m_en22 = 1'b0; m_enmap = 1'b0;
    end else if (hi) begin
      m_addr[20:15] = d[5:0]; m_en22 = d[6]; m_enmap = d[7];
    end
    if (be) begin
      m_be = d[1:0]; m_sticky = d[2];
    end
    if (cv && !(lo || hi || be)) begin
      if (ci && !cwin) begin
        sum = {1'b0, m_addr} + 22'd1;
        m_addr = sum[20:0];
      end
      if (cw && !m_sticky) m_be = 2'b11;
    end
    @(negedge clk);
    lo_wr = 0; hi_wr = 0; be_wr = 0; cmd_valid = 0; cmd_write = 0;
    cmd_incr = 0; cmd_window = 0;
  endtask

  task automatic wlo(input logic [15:0] d); step(1,0,0,d,0,0,0,0,12'd0,""); endtask
  task automatic whi(input logic [15:0] d); step(0,1,0,d,0,0,0,0,12'd0,""); endtask
  task automatic wbe(input logic [15:0] d); step(0,0,1,d,0,0,0,0,12'd0,""); endtask
  task automatic mem(input logic w, input logic inc, input string tag);
    step(0,0,0,16'd0,1,w,inc,0,12'd0,tag);
  endtask
  task automatic win(input logic w, input logic [12:1] off, input string tag);
    step(0,0,0,16'd0,1,w,0,1,off,tag);
  endtask

  // monitor: pops and compares one item per request
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && bus_valid) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected request", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(),
                {5'd0, bus_write, bus_addr, bus_racc, bus_be, bus_en22, bus_enmap},
                {5'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lo_wr = 0; hi_wr = 0; be_wr = 0; wr_data = 0;
    cmd_valid = 0; cmd_write = 0; cmd_incr = 0; cmd_window = 0; cmd_offset = 0;
    m_addr = 0; m_en22 = 0; m_enmap = 0; m_be = 2'b11; m_sticky = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 bus_valid after reset", {31'd0, bus_valid}, 32'd0);

    // R1: reset state seen through plain and window reads
    mem(0, 0, "R1 plain read after reset");
    win(0, 12'o0, "R1 window read shows be 11");

    // R2 / R3 loads
    wlo(16'o123456);
    mem(0, 0, "R2 low load");
    whi(16'h00C5);
    mem(1, 0, "R3 high load keeps low bits");
    wlo(16'o000100);
    mem(0, 0, "R2 low write clears high and modes");

    // R5 back-to-back increments, write increments too
    mem(0, 1, "R5 incr read 0");
    mem(0, 1, "R5 incr read 1");
    mem(1, 1, "R5 incr write 2");
    mem(0, 0, "R5 after three increments");
    mem(0, 0, "R5 no incr keeps address");

    // R5 wrap with 22-bit mode set
    wlo(16'hFFFE);
    whi(16'h007F);
    mem(0, 1, "R5 all ones before wrap");
    mem(0, 0, "R5 wrapped to zero, en22 kept");

    // R7 window ignores stored address and forces modes off
    win(0, 12'o7777, "R7 window high offset, modes forced off");
    step(0,0,0,16'd0,1,0,1,1,12'o0042,"R7 window with incr");
    mem(0, 0, "R7 stored address unchanged by window");

    // R6 / R8 byte enables
    wbe(16'h0001);
    win(0, 12'o0010, "R6 window read shows be 01");
    win(1, 12'o0011, "R8 window write shows be 01");
    win(0, 12'o0012, "R8 non-sticky reverted after window write");
    wbe(16'h0006);
    win(1, 12'o0020, "R6 sticky be 10 on window write");
    mem(1, 0, "R4 plain write presents be 11");
    win(0, 12'o0021, "R8 sticky be kept after writes");
    wbe(16'h0001);
    mem(0, 0, "R4 plain read presents be 11");
    win(0, 12'o0030, "R8 read leaves be 01");
    mem(1, 0, "R8 plain write");
    win(0, 12'o0031, "R8 reverted after plain write");

    // R9 collisions
    wlo(16'o000200);
    step(1,0,0,16'o000400,1,0,1,0,12'd0,"R9 command with low write uses old address");
    mem(0, 0, "R9 low write taken, increment dropped");
    wbe(16'h0001);
    step(0,0,1,16'h0002,1,1,0,1,12'o0040,"R9 window write with be write uses old be");
    win(0, 12'o0041, "R9 new be kept, fallback dropped");

    // R2 priority of low over high in one cycle
    wlo(16'o000002);
    whi(16'h00C1);
    step(1,1,0,16'o177776,0,0,0,0,12'd0,"");
    mem(0, 0, "R2 low wins over high");

    repeat (4) @(negedge clk);
    check("R4 all requests seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule